// File: doc/BRIEF.md
# Sub-Word Message Word Packer with Block-Sized DMA Request

This block sits in front of a hash engine's message input. A bus master, usually a DMA channel, writes a single data register with byte, halfword or word accesses. The block collects these pieces in little-endian lane order until 32 bits are present. It then commits the word to the engine with a one-cycle valid pulse. A bypass input controls byte reversal of the committed word. When the bypass is low, which is the tie-off default, the word is reversed, so the first byte of a buffer becomes the most significant byte, as the hash expects. Because of this, the same byte buffer gives the same message words whatever access size the DMA uses.

The block also drives a DMA request. The request asks for a whole block's worth of transfers at once: 16 words, 32 halfwords or 64 bytes, chosen by a configured size. It is raised only while the engine reports ready. It drops once the full count has been accepted, and it stays low until the engine has been busy at least one cycle. A start pulse restarts both the partial word and the transfer count.

Top module: `msg_word_packer`

## Requirements
- R1: Byte writes (`wrSize` = 0, data in `wrData[7:0]`) fill the word from bits 7:0 upward. With `noSwap` = 1, the fourth byte commits the word {b3,b2,b1,b0}, where b0 is the first byte written.
- R2: Halfword writes (`wrSize` = 1, data in `wrData[15:0]`) fill bits 15:0 first, then bits 31:16. With `noSwap` = 1, the second halfword commits {h1,h0}.
- R3: `wordValid` is high for exactly one cycle, in the cycle after the write that completes 32 bits. A write that leaves the word partial produces no pulse.
- R4: With `noSwap` = 0, the committed word has its four bytes reversed, so the first byte written sits in bits 31:24.
- R5: A `wrSize` of 2 or 3 is a full-word write and commits `wrData` on its own, reversed or not according to R4.
- R6: With `engReady` high, `dmaReq` stays high until a block's count of writes has been accepted, then goes low. The count is 64 for `cfgSize` = 0, 32 for `cfgSize` = 1, and 16 for `cfgSize` = 2 or 3.
- R7: `dmaReq` is low in every cycle in which `engReady` is low.
- R8: After a block completes, `dmaReq` stays low even while `engReady` stays high. Once `engReady` has been low for at least one cycle, `dmaReq` follows `engReady` again.
- R9: A `start` pulse discards any partial word and restarts the transfer count. A write in the same cycle as `start` is dropped.
- R10: After reset, no word is valid and `dmaReq` equals `engReady`.
- R11: One 64-byte buffer yields identical committed words when it is written as bytes, as halfwords or as words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Restart pulse for the partial word and transfer count |
| wrEn | input | 1 | Data register write strobe |
| wrData | input | 32 | Write data, sub-word data in the low lanes |
| wrSize | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| cfgSize | input | 2 | Configured DMA transfer size: 0 byte, 1 halfword, 2/3 word |
| noSwap | input | 1 | 1 bypasses byte reversal of committed words |
| engReady | input | 1 | Engine can take a new block |
| wordOut | output | 32 | Committed message word |
| wordValid | output | 1 | One-cycle pulse marking a new `wordOut` |
| dmaReq | output | 1 | Block-sized DMA request |

## Verification
One 64-byte buffer is sent as 64 byte writes, 32 halfword writes, 16 word writes with size code 2, and 16 word writes with size code 3. Comparing the byte and halfword runs against the word run separates faults in lane placement and fill counting from faults in the commit path. Running with reversal both on and off exposes a swap that is missing, inverted or applied to partial data. A start that lands in the middle of a word, and one that coincides with a write, shows whether stale lanes or stale counts survive a restart. The request is sampled next to the last transfer of each block size and through engine busy periods, which separates off-by-one block lengths from wrong re-arming.

// File: rtl/packer_pkg.sv
package packer_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic load;
  } pack_ctl_t;

  function automatic logic [31:0] byteRev32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/pack_datapath.sv
module pack_datapath
  import packer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  pack_ctl_t         ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        wrSize,
  input  logic              noSwap,
  output logic [DATA_W-1:0] wordOut,
  output logic              wordValid
);
  localparam int LANES = DATA_W / 8;
  localparam int PW    = $clog2(LANES) + 1;

  logic [DATA_W-1:0] acc, nextAcc, swapped, commitWord;
  logic [PW-1:0]     fill, step, total;
  logic              done;

  always_comb begin
    nextAcc = acc;
    step    = PW'(LANES);
    if (wrSize == SZ_BYTE) begin
      step = PW'(1);
      for (int l = 0; l < LANES; l++)
        if (l == int'(fill)) nextAcc[l*8 +: 8] = wrData[7:0];
    end else if (wrSize == SZ_HALF) begin
      step = PW'(2);
      for (int l = 0; l < LANES; l++) begin
        if (l == int'(fill))     nextAcc[l*8 +: 8] = wrData[7:0];
        if (l == int'(fill) + 1) nextAcc[l*8 +: 8] = wrData[15:8];
      end
    end else begin
      nextAcc = wrData;
    end
    total = fill + step;
    done  = (total >= PW'(LANES));
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rev
    assign swapped[g*8 +: 8] = nextAcc[(LANES-1-g)*8 +: 8];
  end

  assign commitWord = noSwap ? nextAcc : swapped;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      fill      <= '0;
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else if (ctl.clear) begin
      acc       <= '0;
      fill      <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= 1'b0;
      if (ctl.load) begin
        if (done) begin
          wordOut   <= commitWord;
          wordValid <= 1'b1;
          acc       <= '0;
          fill      <= '0;
        end else begin
          acc  <= nextAcc;
          fill <= total;
        end
      end
    end
  end

  // R3
  wvalid_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> $past(ctl.load && !ctl.clear));

  // R3
  fill_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    fill < PW'(LANES));

  // R4
  word_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !ctl.clear && wrSize[1] && !noSwap && fill == '0 && DATA_W == 32)
      |=> (wordValid && wordOut == byteRev32(32'($past(wrData)))));

endmodule

// File: rtl/pack_control.sv
module pack_control
  import packer_pkg::*;
#(
  parameter int BLOCK_WORDS = 16,
  parameter int LANES       = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      wrEn,
  input  logic [1:0] cfgSize,
  input  logic      engReady,
  output pack_ctl_t ctl,
  output logic      dmaReq
);
  localparam int MAX_XFER = BLOCK_WORDS * LANES;
  localparam int CW       = $clog2(MAX_XFER + 1);

  typedef enum logic {ST_FILL, ST_DONE} blk_state_t;

  blk_state_t    state;
  logic [CW-1:0] xferCnt, blockLen;

  always_comb begin
    case (cfgSize)
      SZ_BYTE: blockLen = CW'(MAX_XFER);
      SZ_HALF: blockLen = CW'(MAX_XFER / 2);
      default: blockLen = CW'(BLOCK_WORDS);
    endcase
  end

  assign ctl.clear = start;
  assign ctl.load  = wrEn && !start;
  assign dmaReq    = (state == ST_FILL) && engReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_FILL;
      xferCnt <= '0;
    end else if (start) begin
      state   <= ST_FILL;
      xferCnt <= '0;
    end else begin
      case (state)
        ST_FILL: if (wrEn) begin
          if (xferCnt == blockLen - CW'(1)) begin
            xferCnt <= '0;
            state   <= ST_DONE;
          end else begin
            xferCnt <= xferCnt + CW'(1);
          end
        end
        ST_DONE: if (!engReady) state <= ST_FILL;
        default: state <= ST_FILL;
      endcase
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferCnt < blockLen);

  // R9
  start_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (dmaReq == engReady));

endmodule

// File: rtl/msg_word_packer.sv
module msg_word_packer
  import packer_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int BLOCK_WORDS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        wrSize,
  input  logic [1:0]        cfgSize,
  input  logic              noSwap,
  input  logic              engReady,
  output logic [DATA_W-1:0] wordOut,
  output logic              wordValid,
  output logic              dmaReq
);
  localparam int LANES = DATA_W / 8;

  pack_ctl_t ctl;

  pack_control #(.BLOCK_WORDS(BLOCK_WORDS), .LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .wrEn(wrEn),
    .cfgSize(cfgSize), .engReady(engReady), .ctl(ctl), .dmaReq(dmaReq)
  );

  pack_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData), .wrSize(wrSize),
    .noSwap(noSwap), .wordOut(wordOut), .wordValid(wordValid)
  );

endmodule

// File: tb/msg_word_packer_bench.sv
module msg_word_packer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN, start, wrEn, noSwap, engReady;
  logic [31:0] wrData;
  logic [1:0]  wrSize, cfgSize;
  logic [31:0] wordOut;
  logic        wordValid, dmaReq;

  int total = 0, bad = 0;
  logic [31:0] expQ[$];
  logic [7:0]  msg[64];
  logic [31:0] capt[6][16];
  int runId = 0, capIdx = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_word_packer u_msg_word_packer (
    .clk(clk), .rstN(rstN), .start(start), .wrEn(wrEn), .wrData(wrData),
    .wrSize(wrSize), .cfgSize(cfgSize), .noSwap(noSwap), .engReady(engReady),
    .wordOut(wordOut), .wordValid(wordValid), .dmaReq(dmaReq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: R1 R2 R3 R4 R5
  always @(negedge clk) begin
    if (rstN && wordValid) begin
      if (expQ.size() == 0) begin
        chk(0, "R3 unexpected commit", wordOut, 32'h0);
      end else begin
        logic [31:0] e;
        e = expQ.pop_front();
        chk(wordOut == e, "R1/R2/R4/R5 word", wordOut, e);
        if (capIdx < 16) capt[runId][capIdx] = wordOut;
        capIdx++;
      end
    end
  end

  function automatic logic [31:0] expWord(input int i, input logic ns);
    logic [31:0] le;
    le = {msg[4*i+3], msg[4*i+2], msg[4*i+1], msg[4*i]};
    return ns ? le : {msg[4*i], msg[4*i+1], msg[4*i+2], msg[4*i+3]};
  endfunction

  task automatic putWrite(input logic [1:0] sz, input logic [31:0] d, input bit withStart);
    @(negedge clk);
    wrEn = 1'b1; wrSize = sz; wrData = d; start = withStart;
    @(negedge clk);
    wrEn = 1'b0; start = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // driver: one full block of msg with given access size
  task automatic sendBlock(input logic [1:0] sz, input int nRun);
    int n;
    runId = nRun; capIdx = 0;
    n = (sz == 2'd0) ? 64 : (sz == 2'd1) ? 32 : 16;
    for (int k = 0; k < n; k++) begin
      if (sz == 2'd0) begin
        if (k % 4 == 3) expQ.push_back(expWord(k/4, noSwap));
        putWrite(sz, {24'h0, msg[k]}, 0);
      end else if (sz == 2'd1) begin
        if (k % 2 == 1) expQ.push_back(expWord(k/2, noSwap));
        putWrite(sz, {16'h0, msg[2*k+1], msg[2*k]}, 0);
      end else begin
        expQ.push_back(expWord(k, noSwap));
        putWrite(sz, {msg[4*k+3], msg[4*k+2], msg[4*k+1], msg[4*k]}, 0);
      end
      if (k == n-2) chk(dmaReq == 1'b1, "R6 req held before last", {31'h0, dmaReq}, 32'h1);
    end
    chk(dmaReq == 1'b0, "R6 req drops after block", {31'h0, dmaReq}, 32'h0);
  endtask

  // engine model: busy for a few cycles
  task automatic engineCycle();
    repeat (2) @(negedge clk);
    chk(dmaReq == 1'b0, "R8 stays low while ready", {31'h0, dmaReq}, 32'h0);
    engReady = 1'b0;
    @(negedge clk);
    chk(dmaReq == 1'b0, "R7 low when not ready", {31'h0, dmaReq}, 32'h0);
    @(negedge clk);
    engReady = 1'b1;
    #1;
    chk(dmaReq == 1'b1, "R8 re-armed", {31'h0, dmaReq}, 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; start = 1'b0; wrEn = 1'b0; wrData = '0; wrSize = 2'd0;
    cfgSize = 2'd0; noSwap = 1'b0; engReady = 1'b1;
    for (int i = 0; i < 64; i++) msg[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10
    chk(wordValid == 1'b0, "R10 no valid after reset", {31'h0, wordValid}, 32'h0);
    chk(dmaReq == 1'b1, "R10 req follows ready", {31'h0, dmaReq}, 32'h1);

    noSwap = 1'b1;
    cfgSize = 2'd0; pulseStart(); sendBlock(2'd0, 0); engineCycle();  // R1
    cfgSize = 2'd1; pulseStart(); sendBlock(2'd1, 1); engineCycle();  // R2
    cfgSize = 2'd2; pulseStart(); sendBlock(2'd2, 2); engineCycle();  // R5
    noSwap = 1'b0;
    cfgSize = 2'd3; pulseStart(); sendBlock(2'd3, 3); engineCycle();  // R4 R5 R6
    cfgSize = 2'd0; pulseStart(); sendBlock(2'd0, 4); engineCycle();  // R4

    // R11: same buffer, same words for every access size
    for (int i = 0; i < 16; i++) begin
      chk(capt[1][i] == capt[0][i], "R11 half vs byte", capt[1][i], capt[0][i]);
      chk(capt[2][i] == capt[0][i], "R11 word vs byte", capt[2][i], capt[0][i]);
      chk(capt[4][i] == capt[3][i], "R11 swapped byte vs word", capt[4][i], capt[3][i]);
    end

    // R9: start drops partial word and restarts count; write with start dropped
    noSwap = 1'b1; cfgSize = 2'd2;
    pulseStart();
    runId = 5; capIdx = 0;
    putWrite(2'd0, 32'h0000_00AA, 0);
    putWrite(2'd0, 32'h0000_00BB, 1);
    for (int k = 0; k < 4; k++) begin
      if (k == 3) expQ.push_back({msg[3], msg[2], msg[1], msg[0]});
      putWrite(2'd0, {24'h0, msg[k]}, 0);
    end
    for (int k = 1; k < 13; k++) begin
      expQ.push_back(expWord(k, 1'b1));
      putWrite(2'd2, {msg[4*k+3], msg[4*k+2], msg[4*k+1], msg[4*k]}, 0);
      if (k == 11) chk(dmaReq == 1'b1, "R9 count restarted", {31'h0, dmaReq}, 32'h1);
    end
    chk(dmaReq == 1'b0, "R9 block ends after restart", {31'h0, dmaReq}, 32'h0);
    chk(capt[5][0] == {msg[3], msg[2], msg[1], msg[0]}, "R9 partial discarded",
        capt[5][0], {msg[3], msg[2], msg[1], msg[0]});
    engineCycle();

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R3 all expected words seen", 32'(expQ.size()), 32'h0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule